// File: doc/BRIEF.md
# ASCII Command Bus Bridge

The bridge sits between a byte-level serial receiver/transmitter pair and a simple on-chip register bus. It lets a person at a terminal read and modify registers by typing short text lines. Bytes come in on a valid/ready handshake and are parsed as commands. A write line is `w`, a space, a hex address, a space, hex data and a carriage return. A read line is `r`, a space, a hex address and a carriage return. Once a complete line has been parsed, the bridge asks for the bus, waits for the grant, and issues one write or read strobe.

For a read, the returned byte goes back through the transmit handshake as two ASCII hex characters followed by a carriage return. The bridge takes no new input until the reply has been sent. A line that breaks the syntax is dropped without any bus activity, and the parser waits for the next command letter.

Top module: `asciiBusBridge`

## Requirements
- R1: A line made of 0x77, 0x20, one or more address hex digits, 0x20, one or more data hex digits and 0x0D produces exactly one busWrite pulse. During that pulse, busAddr carries the address and busWrData carries the data.
- R2: A line made of 0x72, 0x20, one or more address hex digits and 0x0D produces exactly one busRead pulse. After that pulse, three bytes are sent on the transmit handshake: the high nibble, then the low nibble of the read byte, then 0x0D.
- R3: The bytes 0x30-0x39, 0x61-0x66 and 0x41-0x46 are hex digits with the values 0-9, 10-15 and 10-15. Each digit shifts the field left by 4 bits. A short field is zero-extended. A long field keeps only its last 4 address digits or its last 2 data digits.
- R4: busReq rises in the cycle after the closing 0x0D is taken and stays high until the strobe cycle ends. The strobe comes in the cycle after the first clock edge at which busGnt is sampled high while busReq is high.
- R5: Each busWrite or busRead pulse lasts exactly one cycle, and the two never occur together.
- R6: The read byte is taken from busRdData one clock edge after the edge that ends the busRead pulse. The first reply byte is offered in the cycle that follows.
- R7: Any byte that breaks the syntax drops the line with no bus cycle. This includes a missing space, a non-hex character in a field, an empty field, a 0x0D that comes too early, a second space in a read line, and any first byte other than 0x77 or 0x72.
- R8: rxReady is high only while a line is being parsed. A byte is taken only on an edge where rxValid and rxReady are both high, and bytes offered while rxReady is low have no effect.
- R9: txValid stays high with txData stable until an edge with txReady high. Reply digits use the characters 0-9 and A-F (0x30-0x39 and 0x41-0x46).
- R10: A synchronous active-high reset returns the parser to idle, clears the fields, and drops busReq, both strobes and txValid. After reset, rxReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| rxData | input | 8 | received byte |
| rxValid | input | 1 | received byte present |
| rxReady | output | 1 | bridge accepts a byte |
| txData | output | 8 | byte to transmit |
| txValid | output | 1 | transmit byte present |
| txReady | input | 1 | transmitter takes the byte |
| busReq | output | 1 | bus request |
| busGnt | input | 1 | bus grant |
| busAddr | output | 16 | bus address |
| busWrData | output | 8 | bus write data |
| busWrite | output | 1 | single-cycle write strobe |
| busRead | output | 1 | single-cycle read strobe |
| busRdData | input | 8 | bus read data |

## Verification
Take the edge that accepts the closing carriage return as edge k. busReq is due right after edge k. The strobe is due one cycle after the first edge that samples the grant high. The read byte is captured on the edge that follows the read strobe, and the first reply character is offered in the cycle after that. The bench model advances on the same edges, reacting to the same accepted bytes, grant and transmit-ready inputs. It compares every output against its prediction at each falling edge. A result that comes one cycle early or late therefore shows up as a mismatch in that exact cycle.

// File: rtl/bridgePkg.sv
package bridgePkg;

  typedef struct packed {
    logic       clrAcc;
    logic       shiftAddr;
    logic       shiftData;
    logic       loadRd;
    logic [3:0] txIdx;
  } ctrlStrobes_t;

  localparam logic [7:0] CH_W     = 8'h77;
  localparam logic [7:0] CH_R     = 8'h72;
  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_CR    = 8'h0D;

  function automatic logic [7:0] nibToAscii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

endpackage

// File: rtl/bridgeDatapath.sv
module bridgeDatapath
  import bridgePkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int RD_DIGITS = DATA_W / 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [7:0]        rxData,
  input  logic [DATA_W-1:0] busRdData,
  output logic              isHex,
  output logic              isSpace,
  output logic              isCr,
  output logic              isW,
  output logic              isR,
  output logic [ADDR_W-1:0] addrAcc,
  output logic [DATA_W-1:0] dataAcc,
  output logic [7:0]        txData
);

  logic       isDigit, isLower, isUpper;
  logic [3:0] nib;
  logic [DATA_W-1:0] rdReg;
  logic [7:0] digitChar [RD_DIGITS];

  // character classification
  assign isDigit = (rxData >= 8'h30) && (rxData <= 8'h39);
  assign isLower = (rxData >= 8'h61) && (rxData <= 8'h66);
  assign isUpper = (rxData >= 8'h41) && (rxData <= 8'h46);
  assign isHex   = isDigit || isLower || isUpper;
  assign isSpace = (rxData == CH_SPACE);
  assign isCr    = (rxData == CH_CR);
  assign isW     = (rxData == CH_W);
  assign isR     = (rxData == CH_R);
  // letters have low nibble 1..6, so adding 9 gives 10..15
  assign nib     = rxData[3:0] + ((isLower || isUpper) ? 4'd9 : 4'd0);

  always_ff @(posedge clk) begin
    if (rst || strb.clrAcc) begin
      addrAcc <= '0;
      dataAcc <= '0;
    end else begin
      if (strb.shiftAddr) addrAcc <= {addrAcc[ADDR_W-5:0], nib};
      if (strb.shiftData) dataAcc <= {dataAcc[DATA_W-5:0], nib};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              rdReg <= '0;
    else if (strb.loadRd) rdReg <= busRdData;
  end

  // one ASCII character per nibble, most significant first
  for (genvar g = 0; g < RD_DIGITS; g++) begin : gDigit
    assign digitChar[g] = nibToAscii(rdReg[4*(RD_DIGITS-1-g) +: 4]);
  end

  always_comb begin
    txData = CH_CR;
    for (int i = 0; i < RD_DIGITS; i++) begin
      if (strb.txIdx == 4'(i)) txData = digitChar[i];
    end
  end

endmodule

// File: rtl/bridgeCtrl.sv
module bridgeCtrl
  import bridgePkg::*;
#(
  parameter int RD_DIGITS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rxValid,
  input  logic         isHex,
  input  logic         isSpace,
  input  logic         isCr,
  input  logic         isW,
  input  logic         isR,
  input  logic         busGnt,
  input  logic         txReady,
  output ctrlStrobes_t strb,
  output logic         rxReady,
  output logic         busReq,
  output logic         busWrite,
  output logic         busRead,
  output logic         txValid
);

  typedef enum logic [3:0] {
    S_IDLE, S_SEP, S_ADDR0, S_ADDR, S_DATA0, S_DATA,
    S_REQ, S_STROBE, S_CAPT, S_TX
  } state_t;

  localparam logic [3:0] LAST_IDX = 4'(RD_DIGITS);

  state_t     state, nextState;
  logic       isWrite, nextIsWrite;
  logic [3:0] txIdx, nextTxIdx;
  logic       take;

  assign take = rxValid && rxReady;

  always_comb begin
    nextState   = state;
    nextIsWrite = isWrite;
    nextTxIdx   = txIdx;
    strb        = '0;
    strb.txIdx  = txIdx;
    case (state)
      S_IDLE: if (take && (isW || isR)) begin
        nextState   = S_SEP;
        nextIsWrite = isW;
        strb.clrAcc = 1'b1;
      end
      S_SEP: if (take) nextState = isSpace ? S_ADDR0 : S_IDLE;
      S_ADDR0: if (take) begin
        if (isHex) begin
          strb.shiftAddr = 1'b1;
          nextState      = S_ADDR;
        end else nextState = S_IDLE;
      end
      S_ADDR: if (take) begin
        if (isHex)                   strb.shiftAddr = 1'b1;
        else if (isSpace && isWrite) nextState = S_DATA0;
        else if (isCr && !isWrite)   nextState = S_REQ;
        else                         nextState = S_IDLE;
      end
      S_DATA0: if (take) begin
        if (isHex) begin
          strb.shiftData = 1'b1;
          nextState      = S_DATA;
        end else nextState = S_IDLE;
      end
      S_DATA: if (take) begin
        if (isHex)     strb.shiftData = 1'b1;
        else if (isCr) nextState = S_REQ;
        else           nextState = S_IDLE;
      end
      S_REQ:    if (busGnt) nextState = S_STROBE;
      S_STROBE: nextState = isWrite ? S_IDLE : S_CAPT;
      S_CAPT: begin
        strb.loadRd = 1'b1;
        nextTxIdx   = 4'd0;
        nextState   = S_TX;
      end
      S_TX: if (txReady) begin
        if (txIdx == LAST_IDX) nextState = S_IDLE;
        else                   nextTxIdx = txIdx + 4'd1;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      isWrite <= 1'b0;
      txIdx   <= 4'd0;
    end else begin
      state   <= nextState;
      isWrite <= nextIsWrite;
      txIdx   <= nextTxIdx;
    end
  end

  assign rxReady  = (state == S_IDLE) || (state == S_SEP) || (state == S_ADDR0) ||
                    (state == S_ADDR) || (state == S_DATA0) || (state == S_DATA);
  assign busReq   = (state == S_REQ) || (state == S_STROBE);
  assign busWrite = (state == S_STROBE) && isWrite;
  assign busRead  = (state == S_STROBE) && !isWrite;
  assign txValid  = (state == S_TX);

endmodule

// File: rtl/asciiBusBridge.sv
module asciiBusBridge
  import bridgePkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              busReq,
  input  logic              busGnt,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              busWrite,
  output logic              busRead,
  input  logic [DATA_W-1:0] busRdData
);

  localparam int RD_DIGITS = DATA_W / 4;

  ctrlStrobes_t strb;
  logic isHex, isSpace, isCr, isW, isR;

  bridgeCtrl #(.RD_DIGITS(RD_DIGITS)) uCtrl (
    .clk(clk), .rst(rst), .rxValid(rxValid),
    .isHex(isHex), .isSpace(isSpace), .isCr(isCr), .isW(isW), .isR(isR),
    .busGnt(busGnt), .txReady(txReady), .strb(strb),
    .rxReady(rxReady), .busReq(busReq), .busWrite(busWrite),
    .busRead(busRead), .txValid(txValid)
  );

  bridgeDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_DIGITS(RD_DIGITS)) uPath (
    .clk(clk), .rst(rst), .strb(strb), .rxData(rxData), .busRdData(busRdData),
    .isHex(isHex), .isSpace(isSpace), .isCr(isCr), .isW(isW), .isR(isR),
    .addrAcc(busAddr), .dataAcc(busWrData), .txData(txData)
  );

endmodule

// File: rtl/bridgeChecker.sv
module bridgeChecker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rxReady,
  input logic              busReq,
  input logic              busGnt,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic              busRead,
  input logic              txValid,
  input logic              txReady,
  input logic [7:0]        txData
);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (busWrite || busRead) |=> !(busWrite || busRead));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(busWrite && busRead));

  assert_strobe_granted_R4: assert property (@(posedge clk) disable iff (rst)
    (busWrite || busRead) |-> (busReq && $past(busGnt)));

  assert_addr_held_R4: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busWrite && !busRead) |=> $stable(busAddr));

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

  assert_busy_blocks_rx_R8: assert property (@(posedge clk) disable iff (rst)
    (txValid || busReq) |-> !rxReady);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!busReq && !txValid && !busWrite && !busRead && rxReady));

endmodule

bind asciiBusBridge bridgeChecker #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/tb_asciiBusBridge.sv
`timescale 1ns/1ps
module tb_asciiBusBridge;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rxData = 8'h00;
  logic rxValid = 1'b0;
  logic txReady = 1'b1;
  logic busGnt = 1'b1;
  logic [7:0] busRdData;
  logic rxReady, txValid, busReq, busWrite, busRead;
  logic [7:0] txData, busWrData;
  logic [15:0] busAddr;

  asciiBusBridge dut (
    .clk(clk), .rst(rst), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady), .busReq(busReq),
    .busGnt(busGnt), .busAddr(busAddr), .busWrData(busWrData), .busWrite(busWrite),
    .busRead(busRead), .busRdData(busRdData)
  );

  always #2 clk = ~clk;

  // register file on the bus: synchronous read
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
      busRdData <= 8'h00;
    end else begin
      if (busWrite) mem[busAddr[7:0]] <= busWrData;
      if (busRead)  busRdData <= mem[busAddr[7:0]];
    end
  end

  int compared = 0, mismatched = 0, cyc = 0;
  int gntMode = 0, txMode = 0;
  string txTag = "R6";
  bit started = 0, finished = 0;

  // behavioural reference model
  int phase = 0;
  bit mW = 0;
  logic [15:0] mAddr = 0;
  logic [7:0] mData = 0, mRd = 0;
  int mIdx = 0;
  bit tk;

  function automatic bit hexOk(logic [7:0] b);
    return (b >= "0" && b <= "9") || (b >= "a" && b <= "f") || (b >= "A" && b <= "F");
  endfunction

  function automatic logic [3:0] hexNum(logic [7:0] b);
    if (b >= "a") return 4'(b - "a" + 10);
    if (b >= "A") return 4'(b - "A" + 10);
    return 4'(b - "0");
  endfunction

  function automatic logic [7:0] hexChar(logic [3:0] n);
    return (n < 10) ? 8'("0" + n) : 8'("A" + n - 10);
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      phase = 0; mW = 0; mAddr = 0; mData = 0; mRd = 0; mIdx = 0;
    end else begin
      tk = rxValid && (phase <= 5);
      case (phase)
        0: if (tk && (rxData == 8'h77 || rxData == 8'h72)) begin
             mW = (rxData == 8'h77); mAddr = 0; mData = 0; phase = 1;
           end
        1: if (tk) phase = (rxData == 8'h20) ? 2 : 0;
        2: if (tk) begin
             if (hexOk(rxData)) begin mAddr = {mAddr[11:0], hexNum(rxData)}; phase = 3; end
             else phase = 0;
           end
        3: if (tk) begin
             if (hexOk(rxData)) mAddr = {mAddr[11:0], hexNum(rxData)};
             else if (rxData == 8'h20 && mW) phase = 4;
             else if (rxData == 8'h0D && !mW) phase = 6;
             else phase = 0;
           end
        4: if (tk) begin
             if (hexOk(rxData)) begin mData = {mData[3:0], hexNum(rxData)}; phase = 5; end
             else phase = 0;
           end
        5: if (tk) begin
             if (hexOk(rxData)) mData = {mData[3:0], hexNum(rxData)};
             else if (rxData == 8'h0D) phase = 6;
             else phase = 0;
           end
        6: if (busGnt) phase = 7;
        7: phase = mW ? 0 : 8;
        8: begin mRd = mem[mAddr[7:0]]; mIdx = 0; phase = 9; end
        9: if (txReady) begin
             if (mIdx == 2) phase = 0;
             else mIdx++;
           end
        default: phase = 0;
      endcase
    end
  end

  task automatic cmp(string rq, string nm, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", rq, nm, cyc, act, exp);
    end
  endtask

  logic [7:0] expChar;
  always @(negedge clk) begin
    if (started && !finished) begin
      if (rst) begin
        cmp("R10", "busReq", 32'(busReq), 0);
        cmp("R10", "txValid", 32'(txValid), 0);
        cmp("R10", "rxReady", 32'(rxReady), 1);
      end else begin
        cmp("R8", "rxReady", 32'(rxReady), 32'(phase <= 5));
        cmp("R4", "busReq", 32'(busReq), 32'(phase == 6 || phase == 7));
        cmp((phase == 7 && mW) ? "R1" : "R5", "busWrite", 32'(busWrite), 32'(phase == 7 && mW));
        cmp((phase == 7 && !mW) ? "R2" : "R5", "busRead", 32'(busRead), 32'(phase == 7 && !mW));
        if (phase == 7) begin
          cmp("R3", "busAddr", 32'(busAddr), 32'(mAddr));
          if (mW) cmp("R3", "busWrData", 32'(busWrData), 32'(mData));
        end
        cmp("R9", "txValid", 32'(txValid), 32'(phase == 9));
        if (phase == 9) begin
          expChar = (mIdx == 0) ? hexChar(mRd[7:4]) : (mIdx == 1) ? hexChar(mRd[3:0]) : 8'h0D;
          cmp((mIdx == 2) ? "R2" : txTag, "txData", 32'(txData), 32'(expChar));
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    cyc++;
    rxValid = 1'b0;
    busGnt  = (gntMode == 0) ? 1'b1 : ((cyc % 7) == 0);
    txReady = (txMode == 0) ? 1'b1 : ((cyc % 3) == 0);
  endtask

  task automatic sendStr(string s);
    for (int i = 0; i < s.len(); i++) begin
      tick();
      rxValid = 1'b1;
      rxData  = s[i];
      tick();
    end
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && phase != 0; i++) tick();
    tick();
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #800000;
    mismatched++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    rst = 1'b1;
    repeat (4) tick();
    rst = 1'b0;
    // R1/R2/R6: basic write then read back
    sendStr("w 4cd9 1a\015"); waitIdle();
    sendStr("r 4cd9\015");    waitIdle();
    // R3/R9: short uppercase fields, stalled transmitter
    txMode = 1;
    sendStr("w d9 A5\015"); waitIdle();
    txTag = "R3";
    sendStr("r D9\015");    waitIdle();
    // R3: over-long address and short data
    sendStr("w 12345 7\015"); waitIdle();
    sendStr("r 45\015");      waitIdle();
    // R4: grant withheld most cycles
    gntMode = 1;
    sendStr("w Fe 3C\015");  waitIdle();
    sendStr("r 00fe\015");   waitIdle();
    gntMode = 0;
    // R7: malformed lines, then verify nothing was written
    txTag = "R7";
    sendStr("w4\015");
    sendStr("r \015");
    sendStr("w 12 \015");
    sendStr("w 33 zz\015");
    sendStr("x 12\015");
    sendStr("r 3g\015");
    sendStr("r 12 \015");
    waitIdle();
    sendStr("r 33\015"); waitIdle();
    sendStr("r 12\015"); waitIdle();
    // R8: bytes arriving while busy
    txTag = "R8";
    sendStr("r 4cd9\015w 10 55\015"); waitIdle();
    sendStr("r 10\015"); waitIdle();
    // R10: reset in the middle of a line
    txMode = 0;
    sendStr("w 77 ");
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    sendStr("\015"); waitIdle();
    txTag = "R10";
    sendStr("r 77\015"); waitIdle();
    repeat (4) tick();
    summary();
  end

endmodule